// File: doc/BRIEF.md
# Six-Operation Multicycle Processor Core

This block is a compact programmable core that executes 16-bit machine words. A controller walks each instruction through three one-cycle phases: fetch the word into an instruction register while stepping the program counter, decode it and capture register operands, then execute. Local state is a sixteen-entry register file. Arithmetic runs only on register values, so a memory-to-memory sum is written as loads, an ALU operation and a store.

The core reads instructions through an address/data port and accesses a 256-word data space through address, read-data, write-data and write-enable pins. Both memories sit outside the block. Their read data must be valid in the same cycle as the address (combinational read), and data writes are taken on the clock edge that ends the write-enable cycle. The operations are load, store, add, subtract, load-constant and a relative jump-if-zero. The other ten opcode values do nothing except advance the program counter.

Top module: `proc_core`

## Requirements
- R1: A synchronous active-high reset puts the controller in an initial phase with PC = 0. The first fetch, at instruction address 0, happens in the cycle after reset is released, and no data write occurs during reset or initialisation.
- R2: Every instruction takes exactly three cycles (fetch, decode, execute), and fetch advances PC by one. The execute cycle of the N-th executed instruction is therefore cycle 3N after reset release, where cycle 1 is the first fetch.
- R3: Opcode 0000 (word bits [15:12]) loads the data word at address bits [7:0] into the register selected by bits [11:8].
- R4: Opcode 0001 writes the register selected by bits [11:8] to data address bits [7:0]. The write enable is high for exactly one cycle, the execute cycle, and is never high for any other opcode.
- R5: Opcode 0010 writes reg[bits 11:8] = reg[bits 7:4] + reg[bits 3:0], wrapping modulo 2^DW.
- R6: Opcode 0100 writes reg[bits 11:8] = reg[bits 7:4] - reg[bits 3:0], wrapping modulo 2^DW.
- R7: Opcode 0011 writes the 8-bit constant in bits [7:0], zero-extended to DW bits, into reg[bits 11:8].
- R8: Opcode 0101 tests reg[bits 11:8]. If it is zero, the next fetch is taken from the jump's own address plus bits [7:0] read as a signed byte. Otherwise the next fetch is the following address.
- R9: Opcodes 0110 through 1111 change no register, issue no data write and only advance PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IA_W | Instruction address (current PC) |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 8 | Data address, instruction bits [7:0] |
| dmem_rdata | input | DW | Data word at dmem_addr |
| dmem_wdata | output | DW | Store data |
| dmem_we | output | 1 | Store strobe, one execute cycle |

## Verification
A wrong phase or a wrong PC step shows within one to three cycles on imem_addr, which leaves the expected address-every-third-cycle pattern. It also shifts the cycle in which a store strobe appears, so end-to-end cycle counts on programs with and without taken jumps catch it. A bad register file entry, operand capture or ALU result reaches the ports only when a later store writes it out, so each test program ends by storing every register it touched, including those a no-op opcode must leave alone. A mistimed or repeated write enable shows as an extra write or a changed sentinel word in data memory on the next clock edge.

// File: rtl/proc_pkg.sv
package proc_pkg;

    localparam int INSTR_W = 16;
    localparam int REG_AW  = 4;
    localparam int NREG    = 1 << REG_AW;
    localparam int DADDR_W = 8;
    localparam int IMM_W   = 8;

    localparam logic [3:0] OP_LOAD  = 4'h0;
    localparam logic [3:0] OP_STORE = 4'h1;
    localparam logic [3:0] OP_ADD   = 4'h2;
    localparam logic [3:0] OP_LDC   = 4'h3;
    localparam logic [3:0] OP_SUB   = 4'h4;
    localparam logic [3:0] OP_JMPZ  = 4'h5;

    typedef struct packed {
        logic [3:0]        opc;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
        logic [REG_AW-1:0] rc;
    } instr_t;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_EXEC   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_PASS = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    rf_we;
        logic    wb_mem;
        alu_op_e alu_op;
        logic    mem_we;
        logic    jmpz;
    } ctrl_t;

    function automatic logic [IMM_W-1:0] imm_of(input instr_t w);
        return {w.rb, w.rc};
    endfunction

    function automatic ctrl_t decode_op(input logic [3:0] opc);
        ctrl_t c;
        c = '{rf_we: 1'b0, wb_mem: 1'b0, alu_op: ALU_ADD, mem_we: 1'b0, jmpz: 1'b0};
        case (opc)
            OP_LOAD:  begin c.rf_we = 1'b1; c.wb_mem = 1'b1; end
            OP_STORE: c.mem_we = 1'b1;
            OP_ADD:   begin c.rf_we = 1'b1; c.alu_op = ALU_ADD; end
            OP_LDC:   begin c.rf_we = 1'b1; c.alu_op = ALU_PASS; end
            OP_SUB:   begin c.rf_we = 1'b1; c.alu_op = ALU_SUB; end
            OP_JMPZ:  c.jmpz = 1'b1;
            default:  ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/proc_regfile.sv
module proc_regfile
    import proc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    input  logic [REG_AW-1:0] raddr_c,
    output logic [DW-1:0]     rdata_a,
    output logic [DW-1:0]     rdata_b,
    output logic [DW-1:0]     rdata_c
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (waddr == REG_AW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_c = regs[raddr_c];

endmodule

// File: rtl/proc_alu.sv
module proc_alu
    import proc_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [IMM_W-1:0] imm,
    output logic [DW-1:0]    y
);

    always_comb begin
        case (op)
            ALU_SUB:  y = a - b;
            ALU_PASS: y = DW'(imm);
            default:  y = a + b;
        endcase
    end

    // R6
    always_comb begin
        if (!$isunknown({op, a, b}) && op == ALU_SUB) begin
            sub_inverse_chk: assert (DW'(y + b) == a);
        end
    end

endmodule

// File: rtl/proc_ctrl.sv
module proc_ctrl
    import proc_pkg::*;
#(
    parameter int IA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic               reg_zero,
    output logic [IA_W-1:0]    pc_o,
    output instr_t             ir_o,
    output phase_e             phase_o,
    output ctrl_t              ctl_o
);

    phase_e          phase_q;
    logic [IA_W-1:0] pc_q;
    instr_t          ir_q;
    logic [IA_W-1:0] off_ext;
    logic [IA_W-1:0] jump_tgt;
    logic [IMM_W-1:0] imm;

    assign imm = imm_of(ir_q);

    always_comb begin
        for (int i = 0; i < IA_W; i++) begin
            off_ext[i] = (i < IMM_W) ? imm[i % IMM_W] : imm[IMM_W-1];
        end
    end

    // PC already points past the jump; the offset counts from the jump itself
    assign jump_tgt = pc_q - IA_W'(1) + off_ext;
    assign ctl_o    = decode_op(ir_q.opc);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_INIT;
            pc_q    <= '0;
            ir_q    <= '0;
        end else begin
            case (phase_q)
                ST_INIT: begin
                    pc_q    <= '0;
                    phase_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    ir_q    <= instr_t'(imem_rdata);
                    pc_q    <= pc_q + IA_W'(1);
                    phase_q <= ST_DECODE;
                end
                ST_DECODE: phase_q <= ST_EXEC;
                default: begin
                    if (ctl_o.jmpz && reg_zero) pc_q <= jump_tgt;
                    phase_q <= ST_FETCH;
                end
            endcase
        end
    end

    assign pc_o    = pc_q;
    assign ir_o    = ir_q;
    assign phase_o = phase_q;

    // R1
    init_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_INIT |=> (phase_q == ST_FETCH && pc_q == '0));

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_FETCH |=> phase_q == ST_DECODE);

    // R2
    decode_order_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_DECODE |=> phase_q == ST_EXEC);

    // R2
    exec_order_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_EXEC |=> phase_q == ST_FETCH);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_FETCH |=> pc_q == $past(pc_q) + IA_W'(1));

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_EXEC && !ctl_o.jmpz) |=> $stable(pc_q));

    // R8
    jump_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_EXEC && ctl_o.jmpz && !reg_zero) |=> $stable(pc_q));

endmodule

// File: rtl/proc_core.sv
module proc_core
    import proc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IA_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    input  logic [DW-1:0]      dmem_rdata,
    output logic [DW-1:0]      dmem_wdata,
    output logic               dmem_we
);

    instr_t          ir;
    phase_e          phase;
    ctrl_t           ctl;
    logic [IA_W-1:0] pc;
    logic            in_exec;
    logic            rf_we;
    logic [DW-1:0]   rd_a, rd_b, rd_c;
    logic [DW-1:0]   opa_q, opb_q, val_a_q;
    logic [DW-1:0]   alu_y, wb_data;

    proc_ctrl #(.IA_W(IA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .imem_rdata (imem_rdata),
        .reg_zero   (val_a_q == '0),
        .pc_o       (pc),
        .ir_o       (ir),
        .phase_o    (phase),
        .ctl_o      (ctl)
    );

    assign in_exec = (phase == ST_EXEC);
    assign rf_we   = in_exec && ctl.rf_we;

    proc_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (ir.ra),
        .wdata   (wb_data),
        .raddr_a (ir.ra),
        .raddr_b (ir.rb),
        .raddr_c (ir.rc),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .rdata_c (rd_c)
    );

    // operands are captured in the decode phase
    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q   <= '0;
            opb_q   <= '0;
            val_a_q <= '0;
        end else if (phase == ST_DECODE) begin
            opa_q   <= rd_b;
            opb_q   <= rd_c;
            val_a_q <= rd_a;
        end
    end

    proc_alu #(.DW(DW)) u_alu (
        .op  (ctl.alu_op),
        .a   (opa_q),
        .b   (opb_q),
        .imm (imm_of(ir)),
        .y   (alu_y)
    );

    assign wb_data    = ctl.wb_mem ? dmem_rdata : alu_y;
    assign imem_addr  = pc;
    assign dmem_addr  = imm_of(ir);
    assign dmem_wdata = val_a_q;
    assign dmem_we    = in_exec && ctl.mem_we;

    // R4
    we_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    // R4
    we_needs_store_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (ir.opc == OP_STORE && phase == ST_EXEC));

    // R9
    rf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ir.opc > OP_JMPZ) |-> !rf_we);

endmodule

// File: tb/proc_core_tb_top.sv
module proc_core_tb_top;

    localparam int DW   = 16;
    localparam int IA_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IA_W-1:0] imem_addr;
    logic [15:0]     imem_rdata;
    logic [7:0]      dmem_addr;
    logic [DW-1:0]   dmem_rdata;
    logic [DW-1:0]   dmem_wdata;
    logic            dmem_we;

    logic [15:0]   imem [256];
    logic [DW-1:0] dmem [256];

    int total = 0;
    int bad   = 0;
    int we_cnt;
    int dbl_we;
    logic prev_we;

    always #10 clk = ~clk;

    proc_core #(.DW(DW), .IA_W(IA_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we)
    );

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        if (rst) begin
            we_cnt  <= 0;
            dbl_we  <= 0;
            prev_we <= 1'b0;
        end else begin
            if (dmem_we) we_cnt <= we_cnt + 1;
            if (dmem_we && prev_we) dbl_we <= dbl_we + 1;
            prev_we <= dmem_we;
        end
    end

    function automatic logic [15:0] e3(input logic [3:0] op, a, b, c);
        return {op, a, b, c};
    endfunction

    function automatic logic [15:0] e2(input logic [3:0] op, a, input logic [7:0] v);
        return {op, a, v};
    endfunction

    function automatic int exp_count(input logic [DW-1:0] x, y);
        return int'(x != 0) + int'(y != 0);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'hF000;
            dmem[i] = '0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_store(input int addr, input int limit, output int cyc,
                                output bit hit, output logic [DW-1:0] data);
        cyc  = 0;
        hit  = 1'b0;
        data = '0;
        while (!hit && cyc < limit) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (dmem_we && dmem_addr == 8'(addr)) begin
                hit  = 1'b1;
                data = dmem_wdata;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // non-zero counter program, result stored at address 9
    task automatic count_case(input logic [DW-1:0] x, input logic [DW-1:0] y);
        int cyc;
        bit hit;
        logic [DW-1:0] d;
        int n;
        clear_mem();
        imem[0] = e2(4'h3, 4'd0, 8'd0);
        imem[1] = e2(4'h3, 4'd1, 8'd1);
        imem[2] = e2(4'h0, 4'd2, 8'd4);
        imem[3] = e2(4'h5, 4'd2, 8'd2);
        imem[4] = e3(4'h2, 4'd0, 4'd0, 4'd1);
        imem[5] = e2(4'h0, 4'd2, 8'd5);
        imem[6] = e2(4'h5, 4'd2, 8'd2);
        imem[7] = e3(4'h2, 4'd0, 4'd0, 4'd1);
        imem[8] = e2(4'h1, 4'd0, 8'd9);
        dmem[4] = x;
        dmem[5] = y;
        dmem[9] = 16'h5A5A;
        n = 9 - int'(x == 0) - int'(y == 0);
        do_reset();
        run_to_store(9, 200, cyc, hit, d);
        chk(hit, "R4 store to 9 seen", 32'(hit), 32'd1);
        chk(d == DW'(exp_count(x, y)), "R8 count result", 32'(d), 32'(exp_count(x, y)));
        chk(cyc == 3 * n, "R2 cycles to store", 32'(cyc), 32'(3 * n));
        step();
        chk(dmem[9] == DW'(exp_count(x, y)), "R4 memory word 9", 32'(dmem[9]), 32'(exp_count(x, y)));
        chk(we_cnt == 1 && dbl_we == 0, "R4 single strobe", 32'(we_cnt), 32'd1);
    endtask

    task automatic arith_case(input logic [DW-1:0] x, input logic [DW-1:0] y,
                              input logic [7:0] c, input logic [DW-1:0] top,
                              input logic [3:0] nop_op);
        int cyc;
        bit hit;
        logic [DW-1:0] d;
        logic [DW-1:0] s, m;
        clear_mem();
        imem[0]  = e2(4'h0, 4'd1, 8'd10);
        imem[1]  = e2(4'h0, 4'd2, 8'd11);
        imem[2]  = e3(4'h2, 4'd3, 4'd1, 4'd2);
        imem[3]  = e3(4'h4, 4'd4, 4'd1, 4'd2);
        imem[4]  = e2(4'h3, 4'd5, c);
        imem[5]  = e2(nop_op, 4'd1, 8'd16);
        imem[6]  = e2(4'h0, 4'd7, 8'd255);
        imem[7]  = e2(4'h1, 4'd3, 8'd12);
        imem[8]  = e2(4'h1, 4'd4, 8'd13);
        imem[9]  = e2(4'h1, 4'd5, 8'd14);
        imem[10] = e2(4'h1, 4'd7, 8'd17);
        imem[11] = e2(4'h1, 4'd1, 8'd15);
        dmem[10]  = x;
        dmem[11]  = y;
        dmem[16]  = 16'hBEEF;
        dmem[255] = top;
        s = x + y;
        m = x - y;
        do_reset();
        run_to_store(15, 300, cyc, hit, d);
        chk(cyc == 36, "R2 cycles arith", 32'(cyc), 32'd36);
        step();
        chk(dmem[12] == s, "R5 add wrap", 32'(dmem[12]), 32'(s));
        chk(dmem[13] == m, "R6 sub wrap", 32'(dmem[13]), 32'(m));
        chk(dmem[14] == DW'(c), "R7 constant zero-extended", 32'(dmem[14]), 32'(c));
        chk(dmem[17] == top, "R3 load from 255", 32'(dmem[17]), 32'(top));
        chk(dmem[15] == x, "R9 no-op left reg 1", 32'(dmem[15]), 32'(x));
        chk(dmem[16] == 16'hBEEF, "R9 no-op no write", 32'(dmem[16]), 32'hBEEF);
        chk(we_cnt == 5 && dbl_we == 0, "R4 R9 strobe count", 32'(we_cnt), 32'd5);
    endtask

    task automatic jump_case(input int s);
        int cyc;
        bit hit;
        logic [DW-1:0] d;
        int n;
        clear_mem();
        imem[0]  = e2(4'h3, 4'd0, 8'd0);
        imem[1]  = e2(4'h3, 4'd1, 8'd1);
        imem[2]  = e2(4'h3, 4'd6, 8'(s));
        imem[3]  = e2(4'h3, 4'd7, 8'd0);
        imem[4]  = e3(4'h4, 4'd6, 4'd6, 4'd1);
        imem[5]  = e3(4'h2, 4'd7, 4'd7, 4'd1);
        imem[6]  = e2(4'h5, 4'd6, 8'd2);
        imem[7]  = e2(4'h5, 4'd0, 8'hFD);
        imem[8]  = e2(4'h5, 4'd1, 8'd2);
        imem[9]  = e2(4'h1, 4'd7, 8'd20);
        imem[10] = e3(4'h4, 4'd8, 4'd0, 4'd1);
        imem[11] = e2(4'h1, 4'd8, 8'd21);
        dmem[20] = 16'h1234;
        n = 4 + 4 * s - 1 + 4;
        do_reset();
        chk(imem_addr == 0 && !dmem_we, "R1 init phase", 32'(imem_addr), 32'd0);
        step();
        chk(imem_addr == 0, "R1 first fetch at 0", 32'(imem_addr), 32'd0);
        run_to_store(21, 400, cyc, hit, d);
        cyc = cyc + 1;
        chk(cyc == 3 * n, "R8 R2 cycles with loop", 32'(cyc), 32'(3 * n));
        chk(d == 16'hFFFF, "R6 zero minus one", 32'(d), 32'hFFFF);
        step();
        chk(dmem[20] == DW'(s), "R8 loop iterations", 32'(dmem[20]), 32'(s));
    endtask

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        clear_mem();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 0, "R1 reset PC", 32'(imem_addr), 32'd0);
        chk(!dmem_we, "R1 no write in reset", 32'(dmem_we), 32'd0);

        count_case(16'd0, 16'd0);
        count_case(16'd7, 16'd0);
        count_case(16'd0, 16'h8000);
        count_case(16'hFFFF, 16'd1);
        for (int k = 0; k < 6; k++) begin
            logic [DW-1:0] a, b;
            a = ($urandom % 3 == 0) ? '0 : DW'($urandom);
            b = ($urandom % 3 == 0) ? '0 : DW'($urandom);
            count_case(a, b);
        end

        arith_case(16'hFFFF, 16'd1, 8'hFF, 16'hC3C3, 4'h6);
        arith_case(16'd0, 16'd1, 8'h80, 16'h0001, 4'hF);
        for (int k = 0; k < 4; k++) begin
            arith_case(DW'($urandom), DW'($urandom), 8'($urandom), DW'($urandom),
                       4'(6 + ($urandom % 10)));
        end

        jump_case(1);
        jump_case(5);
        jump_case(1 + int'($urandom % 5));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule